// File: doc/BRIEF.md
# Packing Vector Generator

This block turns a word geometry into the packing rules that a serial FIFO uses to split protocol words into byte lanes. Given the number of bits in each protocol word, the number of words held in one FIFO entry and the bit order, it walks a bit index across the entry. It emits one 10-bit packing vector per byte lane, and each vector holds a start index, a direction flag, a length and a stop flag. The vectors are then merged two at a time into two configuration words. It also derives a granularity code and says whether that code should be written.

Software or a sequencer pulses `start` with the three inputs held steady for that cycle. While `busy` is high the block fills one vector per clock. `done` pulses once at the end, and the configuration words, the error flag and the granularity outputs are then valid. They stay valid until the next accepted `start`. A geometry that needs no lanes, or more than four lanes, ends at once with `error` set.

Top module: `pack_vec_gen`

## Requirements
- R1: The lane count is ceil(bitsPerWord/8) x wordsPerEntry. For a count k from 1 to 4, `busy` is high for exactly the k cycles after the edge that accepts `start`. `done` is high for the single cycle that follows, with `busy` low.
- R2: A lane count of 0 or above 4 gives `done` and `error` high together in the cycle after the accepting edge, with both configuration words zero and `granWe` low. `busy` stays low.
- R3: The first vector's start index is bitsPerWord-1 when `msbFirst` is 1 and 0 when it is 0. While a word still has more than 8 bits left, the index moves by -8 when `msbFirst` is 1 and by +8 when it is 0.
- R4: Vector bits [3:1] hold min(bits left in the word, 8) - 1. Bit [4] equals `msbFirst`.
- R5: When 8 or fewer bits of the word are left, the next vector starts at (vector number + 1) x 8 + the first start index, and the bits left reload to bitsPerWord.
- R6: Bit [0] (stop) is set only on vector k-1. Vectors k to 3 are all zero.
- R7: The start index sits in vector bits [9:5]. `cfgWord0` is vector 0 in bits [9:0] and vector 1 in bits [19:10]. `cfgWord1` is vectors 2 and 3 placed the same way. Bits above 19 are zero.
- R8: After a run without error, `granWe` is high in the `done` cycle only if wordsPerEntry is nonzero or bitsPerWord is 32. When it is high, `granCode` equals bitsPerWord/16, rounded down.
- R9: A `start` that arrives while `busy` is high is ignored: it changes neither the timing nor the results of the run in progress.
- R10: While reset is held and after its release, `busy`, `done`, `error` and `granWe` are 0, and both configuration words and `granCode` are 0.
- R11: For 7-bit words, four per entry, MSB first, the start indices are 6, 14, 22 and 30, each length field is 6, and stop is set only on the fourth vector. This gives `cfgWord0` = 0x770DC and `cfgWord1` = 0xF76DC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a computation; sampled only when idle |
| bitsPerWord | input | 6 | Protocol word size, 1 to 32 |
| wordsPerEntry | input | 3 | Protocol words per FIFO entry |
| msbFirst | input | 1 | 1 for MSB-first bit order |
| busy | output | 1 | Vectors are being produced |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | Last run had an unusable lane count |
| cfgWord0 | output | 32 | Vectors 0 and 1 |
| cfgWord1 | output | 32 | Vectors 2 and 3 |
| granCode | output | 2 | Granularity code |
| granWe | output | 1 | Granularity write enable, with done |

## Verification
The assertions take for granted that `bitsPerWord` stays between 0 and 32. Larger sizes are outside the block's range and could yield a lane count the stop-flag checks do not expect. The bench drives only sizes from 0 to 32. Its word counts run from 0 to 7, so both a zero lane count and an overflowing one reach the error path. The inputs change only at falling edges, so each `start` is seen at exactly one rising edge, except where the bench deliberately holds it into a busy run.

// File: rtl/pack_gen_pkg.sv
package pack_gen_pkg;
  localparam int BYTE_BITS = 8;
  localparam int NUM_VEC   = 4;
  localparam int SLOT_W    = $clog2(NUM_VEC);
  localparam int NUM_WORDS = NUM_VEC / 2;

  typedef struct packed {
    logic              load;    // latch inputs, clear vectors
    logic              step;    // produce vector in slot
    logic              last;    // the vector being produced is the final one
    logic              finish;  // successful end of run
    logic [SLOT_W-1:0] slot;
  } pgCtrl_t;
endpackage

// File: rtl/pack_gen_ctrl.sv
module pack_gen_ctrl
  import pack_gen_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] countNow,
  input  logic             countOk,
  output pgCtrl_t          ctrl,
  output logic             busy,
  output logic             done,
  output logic             error
);
  typedef enum logic {ST_IDLE, ST_GEN} pgState_e;

  pgState_e          state;
  logic [CNT_W-1:0]  countQ;
  logic [SLOT_W-1:0] slotQ;
  logic              accept;
  logic              isLast;

  assign accept = (state == ST_IDLE) && start;
  assign isLast = (CNT_W'(slotQ) == countQ - CNT_W'(1));

  always_comb begin
    ctrl        = '0;
    ctrl.load   = accept;
    ctrl.step   = (state == ST_GEN);
    ctrl.last   = (state == ST_GEN) && isLast;
    ctrl.finish = (state == ST_GEN) && isLast;
    ctrl.slot   = slotQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      countQ <= '0;
      slotQ  <= '0;
      done   <= 1'b0;
      error  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        countQ <= countNow;
        slotQ  <= '0;
        error  <= !countOk;
        if (countOk) state <= ST_GEN;
        else         done  <= 1'b1;
      end else if (state == ST_GEN) begin
        slotQ <= slotQ + SLOT_W'(1);
        if (isLast) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
      end
    end
  end

  assign busy = (state == ST_GEN);
endmodule

// File: rtl/pack_gen_datapath.sv
module pack_gen_datapath
  import pack_gen_pkg::*;
#(
  parameter int MAX_BPW = 32,
  parameter int BPW_W   = 6,
  parameter int WPE_W   = 3,
  parameter int CFG_W   = 32,
  parameter int GRAN_W  = 2,
  parameter int CNT_W   = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  pgCtrl_t          ctrl,
  input  logic [BPW_W-1:0] bpwIn,
  input  logic [WPE_W-1:0] wpeIn,
  input  logic             msbIn,
  output logic [CNT_W-1:0] countNow,
  output logic             countOk,
  output logic [CFG_W-1:0] cfgWords [NUM_WORDS],
  output logic [GRAN_W-1:0] granCode,
  output logic             granWe
);
  localparam int START_W    = $clog2(MAX_BPW);
  localparam int LEN_W      = $clog2(BYTE_BITS);
  localparam int VEC_W      = START_W + LEN_W + 2;
  localparam int GRAN_SHIFT = $clog2(2 * BYTE_BITS);

  logic [BPW_W:0]     bpwRound;
  logic [CNT_W-1:0]   bytesPerWord;
  logic [BPW_W-1:0]   bpwQ;
  logic [WPE_W-1:0]   wpeQ;
  logic               msbQ;
  logic [START_W-1:0] initQ;
  logic [START_W-1:0] idxQ;
  logic [BPW_W-1:0]   remQ;
  logic [LEN_W-1:0]   lenField;
  logic               wordEnds;
  logic [START_W-1:0] idxNext;
  logic [VEC_W-1:0]   vecNew;
  logic [VEC_W-1:0]   vecQ [NUM_VEC];

  // lane count from the raw inputs, sampled by the control on start
  assign bpwRound     = {1'b0, bpwIn} + (BPW_W+1)'(BYTE_BITS - 1);
  assign bytesPerWord = CNT_W'(bpwRound >> LEN_W);
  assign countNow     = bytesPerWord * CNT_W'(wpeIn);
  assign countOk      = (countNow != '0) && (countNow <= CNT_W'(NUM_VEC));

  // one lane of the walk
  assign wordEnds = (remQ <= BPW_W'(BYTE_BITS));
  assign lenField = wordEnds ? LEN_W'(remQ - BPW_W'(1)) : LEN_W'(BYTE_BITS - 1);
  assign vecNew   = {idxQ, msbQ, lenField, ctrl.last};

  always_comb begin
    if (wordEnds)
      idxNext = START_W'((START_W'(ctrl.slot) + START_W'(1)) << LEN_W) + initQ;
    else if (msbQ)
      idxNext = idxQ - START_W'(BYTE_BITS);
    else
      idxNext = idxQ + START_W'(BYTE_BITS);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bpwQ  <= '0;
      wpeQ  <= '0;
      msbQ  <= 1'b0;
      initQ <= '0;
      idxQ  <= '0;
      remQ  <= '0;
    end else if (ctrl.load) begin
      bpwQ  <= bpwIn;
      wpeQ  <= wpeIn;
      msbQ  <= msbIn;
      initQ <= msbIn ? START_W'(bpwIn - BPW_W'(1)) : '0;
      idxQ  <= msbIn ? START_W'(bpwIn - BPW_W'(1)) : '0;
      remQ  <= bpwIn;
    end else if (ctrl.step) begin
      idxQ <= idxNext;
      remQ <= wordEnds ? bpwQ : remQ - BPW_W'(BYTE_BITS);
    end
  end

  always_ff @(posedge clk) begin
    for (int v = 0; v < NUM_VEC; v++) begin
      if (!rstN || ctrl.load)
        vecQ[v] <= '0;
      else if (ctrl.step && (ctrl.slot == SLOT_W'(v)))
        vecQ[v] <= vecNew;
    end
  end

  genvar w;
  generate
    for (w = 0; w < NUM_WORDS; w++) begin : g_word
      assign cfgWords[w] = CFG_W'({vecQ[2*w+1], vecQ[2*w]});
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      granCode <= '0;
      granWe   <= 1'b0;
    end else if (ctrl.finish) begin
      granCode <= GRAN_W'(bpwQ >> GRAN_SHIFT);
      granWe   <= (wpeQ != '0) || (bpwQ == BPW_W'(MAX_BPW));
    end else begin
      granWe <= 1'b0;
    end
  end
endmodule

// File: rtl/pack_vec_gen.sv
module pack_vec_gen
  import pack_gen_pkg::*;
#(
  parameter int MAX_BPW = 32,
  parameter int BPW_W   = $clog2(MAX_BPW + 1),
  parameter int WPE_W   = 3,
  parameter int CFG_W   = 32,
  parameter int GRAN_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [BPW_W-1:0]  bitsPerWord,
  input  logic [WPE_W-1:0]  wordsPerEntry,
  input  logic              msbFirst,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [CFG_W-1:0]  cfgWord0,
  output logic [CFG_W-1:0]  cfgWord1,
  output logic [GRAN_W-1:0] granCode,
  output logic              granWe
);
  localparam int CNT_W = BPW_W + WPE_W;

  pgCtrl_t          ctrl;
  logic [CNT_W-1:0] countNow;
  logic             countOk;
  logic [CFG_W-1:0] cfgWords [NUM_WORDS];

  pack_gen_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .countNow(countNow), .countOk(countOk),
    .ctrl(ctrl), .busy(busy), .done(done), .error(error)
  );

  pack_gen_datapath #(
    .MAX_BPW(MAX_BPW), .BPW_W(BPW_W), .WPE_W(WPE_W),
    .CFG_W(CFG_W), .GRAN_W(GRAN_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .bpwIn(bitsPerWord), .wpeIn(wordsPerEntry), .msbIn(msbFirst),
    .countNow(countNow), .countOk(countOk), .cfgWords(cfgWords),
    .granCode(granCode), .granWe(granWe)
  );

  assign cfgWord0 = cfgWords[0];
  assign cfgWord1 = cfgWords[1];
endmodule

// File: rtl/pack_vec_gen_checker.sv
module pack_vec_gen_checker
  import pack_gen_pkg::*;
#(
  parameter int CFG_W = 32,
  parameter int VEC_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             done,
  input logic             error,
  input logic [CFG_W-1:0] cfgWord0,
  input logic [CFG_W-1:0] cfgWord1,
  input logic             granWe
);
  logic [3:0] busyRun;
  logic [3:0] stops;

  always_ff @(posedge clk) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + 4'd1;
    else           busyRun <= '0;
  end

  assign stops = {cfgWord1[VEC_W], cfgWord1[0], cfgWord0[VEC_W], cfgWord0[0]};

  a_r1_busy_bounded: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= 4'(NUM_VEC));
  a_r1_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  a_r1_busy_ends_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  a_r2_error_with_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(error) |-> done);
  a_r2_error_words_zero: assert property (@(posedge clk) disable iff (!rstN)
    (done && error) |-> (cfgWord0 == '0 && cfgWord1 == '0 && !granWe));
  a_r6_single_stop: assert property (@(posedge clk) disable iff (!rstN)
    (done && !error) |-> ($countones(stops) == 1));
  a_r8_we_only_done: assert property (@(posedge clk) disable iff (!rstN)
    granWe |-> (done && !error));
endmodule

bind pack_vec_gen pack_vec_gen_checker #(.CFG_W(CFG_W), .VEC_W($clog2(MAX_BPW) + 5)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .error(error),
  .cfgWord0(cfgWord0), .cfgWord1(cfgWord1), .granWe(granWe)
);

// File: tb/pack_vec_gen_bench.sv
module pack_vec_gen_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  bitsPerWord = '0;
  logic [2:0]  wordsPerEntry = '0;
  logic        msbFirst = 1'b0;
  logic        busy, done, error, granWe;
  logic [31:0] cfgWord0, cfgWord1;
  logic [1:0]  granCode;
  int nTests = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  pack_vec_gen u_pack_vec_gen (
    .clk(clk), .rstN(rstN), .start(start), .bitsPerWord(bitsPerWord),
    .wordsPerEntry(wordsPerEntry), .msbFirst(msbFirst), .busy(busy),
    .done(done), .error(error), .cfgWord0(cfgWord0), .cfgWord1(cfgWord1),
    .granCode(granCode), .granWe(granWe)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference straight from the requirement text
  task automatic refModel(input int bpw, input int words, input bit msb,
                          output int lanes, output longint w0, output longint w1,
                          output bit gwe, output int gcode);
    int vec [4];
    int first, idx, left;
    for (int i = 0; i < 4; i++) vec[i] = 0;
    lanes = ((bpw + 7) / 8) * words;
    w0 = 0; w1 = 0; gwe = 0; gcode = 0;
    if (lanes < 1 || lanes > 4) return;
    first = msb ? bpw - 1 : 0;
    idx = first;
    left = bpw;
    for (int i = 0; i < lanes; i++) begin
      vec[i] = idx * 32 + (msb ? 16 : 0) + ((left < 8 ? left : 8) - 1) * 2;
      if (left <= 8) begin
        idx = (i + 1) * 8 + first;
        left = bpw;
      end else begin
        idx = msb ? idx - 8 : idx + 8;
        left = left - 8;
      end
    end
    vec[lanes-1] += 1;
    w0 = longint'(vec[0]) + longint'(vec[1]) * 1024;
    w1 = longint'(vec[2]) + longint'(vec[3]) * 1024;
    gwe = (words != 0) || (bpw == 32);
    gcode = bpw / 16;
  endtask

  task automatic runJob(input int bpw, input int words, input bit msb,
                        input string tag, input bit poke);
    int lanes, gcode;
    longint w0, w1;
    bit gwe, ok;
    refModel(bpw, words, msb, lanes, w0, w1, gwe, gcode);
    ok = (lanes >= 1 && lanes <= 4);
    @(negedge clk);
    bitsPerWord = 6'(bpw); wordsPerEntry = 3'(words); msbFirst = msb; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (ok) begin
      for (int c = 1; c <= lanes; c++) begin
        chk(busy == 1'b1, "R1", "busy during run", longint'(busy), 1);
        chk(done == 1'b0, "R1", "done during run", longint'(done), 0);
        if (poke && c == 1) begin
          bitsPerWord = 6'd3; wordsPerEntry = 3'd1; msbFirst = !msb; start = 1'b1;
        end else begin
          start = 1'b0;
        end
        @(negedge clk);
      end
      start = 1'b0;
      chk(done == 1'b1 && busy == 1'b0, "R1", "done pulse", longint'({busy, done}), 1);
      chk(error == 1'b0, "R2", "error on valid run", longint'(error), 0);
      chk(longint'(cfgWord0) == w0, tag, "cfgWord0", longint'(cfgWord0), w0);
      chk(longint'(cfgWord1) == w1, tag, "cfgWord1", longint'(cfgWord1), w1);
      chk(granWe == gwe, "R8", "granWe", longint'(granWe), longint'(gwe));
      if (gwe) chk(int'(granCode) == gcode, "R8", "granCode", longint'(granCode), longint'(gcode));
    end else begin
      chk(done == 1'b1 && error == 1'b1 && busy == 1'b0, "R2", "error end",
          longint'({busy, done, error}), 3);
      chk(cfgWord0 == '0 && cfgWord1 == '0, "R2", "words cleared",
          longint'(cfgWord0 | cfgWord1), 0);
      chk(granWe == 1'b0, "R2", "granWe on error", longint'(granWe), 0);
    end
    @(negedge clk);
    chk(done == 1'b0, "R1", "done single cycle", longint'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL R1 watchdog: actual hung expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state, during and after reset
    chk({busy, done, error, granWe} == 4'b0, "R10", "flags in reset",
        longint'({busy, done, error, granWe}), 0);
    chk(cfgWord0 == '0 && cfgWord1 == '0 && granCode == '0, "R10", "data in reset",
        longint'(cfgWord0 | cfgWord1), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk({busy, done, error, granWe} == 4'b0, "R10", "flags after reset",
        longint'({busy, done, error, granWe}), 0);

    // R11: 7-bit words, four per entry, MSB first
    runJob(7, 4, 1'b1, "R11", 1'b0);
    chk(cfgWord0 == 32'h770DC, "R11", "fixed cfgWord0", longint'(cfgWord0), 64'h770DC);
    chk(cfgWord1 == 32'hF76DC, "R11", "fixed cfgWord1", longint'(cfgWord1), 64'hF76DC);

    runJob(15, 2, 1'b0, "R4", 1'b0);   // R4: lengths 7,6,7,6 LSB first
    runJob(9, 2, 1'b1, "R5", 1'b0);    // R5: reload to word boundary mid-entry
    runJob(23, 1, 1'b1, "R6", 1'b0);   // R6: three lanes, vector 3 zero
    runJob(32, 1, 1'b0, "R7", 1'b0);   // R7: all four lanes, field layout
    runJob(16, 1, 1'b0, "R8", 1'b0);   // R8: code 1 written
    runJob(1, 4, 1'b1, "R3", 1'b0);    // R3: one-bit words
    runJob(24, 1, 1'b0, "R9", 1'b1);   // R9: start during busy ignored
    runJob(32, 0, 1'b0, "R2", 1'b0);   // R2: zero lanes even at 32 bits
    runJob(12, 4, 1'b0, "R2", 1'b0);   // R2: eight lanes
    runJob(0, 3, 1'b1, "R2", 1'b0);    // R2: zero-bit words
    runJob(8, 7, 1'b1, "R2", 1'b0);    // R2: seven lanes

    // R3 with R4..R7 across the whole geometry space
    for (int b = 1; b <= 32; b++)
      for (int w = 0; w <= 4; w++)
        for (int m = 0; m < 2; m++)
          runJob(b, w, m[0], "R3", 1'b0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule